// File: doc/BRIEF.md
# Double-Width Funnel Shift Unit

This unit performs a double-precision shift on a 16-bit or 32-bit operand. The destination word moves left or right by a count. The bit positions it vacates are filled from a second word, the fill source, not with zeros. Operand fetch, address generation and memory writes are handled elsewhere. The unit receives the two words, a raw count, a direction bit, a size bit and the current flag vector. It returns the shifted word, a write-enable and an updated flag vector.

Operations enter through a valid/ready input channel and leave through a valid/ready output channel, one operation at a time. `in_ready` is high when the output register is empty, or when it is being drained in the same cycle (`out_ready` high). An accepted operation appears on the output one clock later. It stays there, unchanged, for as long as `out_ready` is low. The unit never drops a result and never overwrites one that has not been taken. A constant port reports the nominal latency of the operation to the scheduler.

Top module: `dshift_unit`

## Requirements
- R1: Only the low 5 bits of `in_cnt` are used. Bits 7:5 have no effect on any output.
- R2: When the masked count is zero, `out_we` is 0, `out_flags` equals `in_flags`, and `out_res` is the destination at the selected size.
- R3: A left shift with a 32-bit operand (`in_dir`=0, `in_wide`=1) returns the upper 32 bits of {dst, src} shifted left by the count.
- R4: A right shift with a 32-bit operand (`in_dir`=1, `in_wide`=1) returns the lower 32 bits of {src, dst} shifted right by the count.
- R5: Carry (flag bit 0) is the last destination bit shifted out. For a left shift this is dst bit (size − count). For a right shift it is dst bit (count − 1). When the count exceeds the operand size, carry is 0.
- R6: Flag bit 2 (zero) is 1 when the sized result is 0. Flag bit 3 (sign) is the result's top bit at the selected size. Flag bit 1 (parity) is 1 when result bits 7:0 hold an even number of ones.
- R7: A 16-bit left shift returns bits 31:16 of the 32-bit word {dst[15:0], src[15:0]} shifted left by the count, with zeros entering from the right. For counts 17 to 31 this takes bits from the fill and then zeros.
- R8: A 16-bit right shift returns bits 15:0 of {src[15:0], dst[15:0]} shifted right by the count, with zeros entering from the left.
- R9: Flag bits 7:4 (overflow at bit 4 and bits 7:5) always pass from `in_flags` to `out_flags` unchanged.
- R10: An operation accepted on a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, every output holds. `in_ready` equals `!out_valid || out_ready`. After reset `out_valid` is 0.
- R11: `lat_cycles` reads 3 at all times, whatever the direction, size or count.
- R12: With a 16-bit operand (`in_wide`=0), `out_res[31:16]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_dst | input | 32 | Destination word (low 16 bits in narrow mode) |
| in_src | input | 32 | Fill source word (low 16 bits in narrow mode) |
| in_cnt | input | 8 | Raw shift count |
| in_dir | input | 1 | 0 = left, 1 = right |
| in_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| in_flags | input | 8 | Incoming flags: bit0 carry, bit1 parity, bit2 zero, bit3 sign, bit4 overflow |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 32 | Shifted result, zero-extended in narrow mode |
| out_we | output | 1 | Result must be written back |
| out_flags | output | 8 | Updated flags, same layout as in_flags |
| lat_cycles | output | 2 | Fixed latency indication (3) |

## Verification
The bound checker watches the handshake on every cycle. It checks that an accepted operation appears on the next cycle and that outputs hold while stalled. It also checks that a zero masked count suppresses the write and leaves the flags unchanged, and that the upper flag bits pass through. On each result it checks right-shift carry, wide sign and the narrow-mode upper zeros. Other behaviour can only be shown by the bench's directed scenarios: the exact funnel contents for counts above 16 in narrow mode, left-shift carry at the size boundary, parity of the low byte, and the masking of high count bits. The bench's randomised back-pressure phase is what exercises acceptance while the output is draining.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
  localparam int FLAG_W = 8;
  localparam int CF_BIT = 0;
  localparam int PF_BIT = 1;
  localparam int ZF_BIT = 2;
  localparam int SF_BIT = 3;
  localparam int OF_BIT = 4;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } dsh_dir_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic parity;
    logic carry;
  } dsh_stat_t;
endpackage

// File: rtl/dsh_barrel.sv
module dsh_barrel #(
  parameter int W    = 64,
  parameter int SW   = 5,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (LEFT) begin : g_left
      assign stage[k+1] = amt[k] ? (stage[k] << STEP) : stage[k];
    end else begin : g_right
      assign stage[k+1] = amt[k] ? (stage[k] >> STEP) : stage[k];
    end
  end

  assign dout = stage[SW];
endmodule

// File: rtl/dsh_count_mask.sv
module dsh_count_mask #(
  parameter int RAW_W = 8,
  parameter int CNT_W = 5
) (
  input  logic [RAW_W-1:0] raw,
  output logic [CNT_W-1:0] cnt,
  output logic             is_zero
);
  logic unused_hi;
  assign unused_hi = ^raw[RAW_W-1:CNT_W];
  assign cnt       = raw[CNT_W-1:0];
  assign is_zero   = (cnt == '0);
endmodule

// File: rtl/dsh_funnel.sv
module dsh_funnel #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dir,
  input  logic              wide,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  import dsh_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam int FUN_W  = 2 * DATA_W;

  logic [FUN_W-1:0]  left_word, right_word, left_sh, right_sh;
  logic [DATA_W-1:0] left_res, right_res;
  logic [CNT_W:0]    size_w;
  logic [CNT_W-1:0]  left_idx, right_idx;
  logic              in_range;

  always_comb begin
    if (wide) begin
      left_word  = {dst, src};
      right_word = {src, dst};
    end else begin
      left_word  = {dst[HALF_W-1:0], src[HALF_W-1:0], {DATA_W{1'b0}}};
      right_word = {{DATA_W{1'b0}}, src[HALF_W-1:0], dst[HALF_W-1:0]};
    end
  end

  dsh_barrel #(.W(FUN_W), .SW(CNT_W), .LEFT(1'b1)) u_left (
    .din(left_word), .amt(cnt), .dout(left_sh)
  );

  dsh_barrel #(.W(FUN_W), .SW(CNT_W), .LEFT(1'b0)) u_right (
    .din(right_word), .amt(cnt), .dout(right_sh)
  );

  always_comb begin
    if (wide) begin
      left_res  = left_sh[FUN_W-1:DATA_W];
      right_res = right_sh[DATA_W-1:0];
    end else begin
      left_res  = {{HALF_W{1'b0}}, left_sh[FUN_W-1:FUN_W-HALF_W]};
      right_res = {{HALF_W{1'b0}}, right_sh[HALF_W-1:0]};
    end
  end

  assign size_w    = wide ? (CNT_W+1)'(DATA_W) : (CNT_W+1)'(HALF_W);
  assign in_range  = ({1'b0, cnt} <= size_w);
  assign left_idx  = size_w[CNT_W-1:0] - cnt;
  assign right_idx = cnt - 1'b1;

  always_comb begin
    if (dsh_dir_e'(dir) == DIR_RIGHT) begin
      res   = right_res;
      carry = in_range & dst[right_idx];
    end else begin
      res   = left_res;
      carry = in_range & dst[left_idx];
    end
  end
endmodule

// File: rtl/dsh_flag_gen.sv
module dsh_flag_gen #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]    res,
  input  logic                 wide,
  input  logic                 carry,
  output dsh_pkg::dsh_stat_t   stat
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    stat.carry  = carry;
    stat.parity = ~^res[7:0];
    if (wide) begin
      stat.zero = (res == '0);
      stat.sign = res[DATA_W-1];
    end else begin
      stat.zero = (res[HALF_W-1:0] == '0);
      stat.sign = res[HALF_W-1];
    end
  end
endmodule

// File: rtl/dshift_unit.sv
module dshift_unit #(
  parameter int DATA_W  = 32,
  parameter int RAW_W   = 8,
  parameter int LATENCY = 3,
  localparam int CNT_W  = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2,
  localparam int LAT_W  = $clog2(LATENCY + 1),
  localparam int FLAG_W = dsh_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [RAW_W-1:0]  in_cnt,
  input  logic              in_dir,
  input  logic              in_wide,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_res,
  output logic              out_we,
  output logic [FLAG_W-1:0] out_flags,
  output logic [LAT_W-1:0]  lat_cycles
);
  import dsh_pkg::*;

  logic [CNT_W-1:0]  cnt;
  logic              cnt_zero;
  logic [DATA_W-1:0] fun_res, dst_sized, res_next;
  logic              fun_carry;
  dsh_stat_t         stat;
  logic [FLAG_W-1:0] flags_next;
  logic              fire;

  dsh_count_mask #(.RAW_W(RAW_W), .CNT_W(CNT_W)) u_mask (
    .raw(in_cnt), .cnt(cnt), .is_zero(cnt_zero)
  );

  dsh_funnel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_funnel (
    .dst(in_dst), .src(in_src), .cnt(cnt), .dir(in_dir), .wide(in_wide),
    .res(fun_res), .carry(fun_carry)
  );

  dsh_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .res(fun_res), .wide(in_wide), .carry(fun_carry), .stat(stat)
  );

  assign dst_sized = in_wide ? in_dst : {{HALF_W{1'b0}}, in_dst[HALF_W-1:0]};
  assign res_next  = cnt_zero ? dst_sized : fun_res;

  always_comb begin
    flags_next = in_flags;
    if (!cnt_zero) begin
      flags_next[CF_BIT] = stat.carry;
      flags_next[PF_BIT] = stat.parity;
      flags_next[ZF_BIT] = stat.zero;
      flags_next[SF_BIT] = stat.sign;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_we    <= 1'b0;
      out_flags <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_res   <= res_next;
      out_we    <= !cnt_zero;
      out_flags <= flags_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign lat_cycles = LAT_W'(LATENCY);
endmodule

// File: rtl/dshift_chk.sv
module dshift_chk #(
  parameter int DATA_W = 32,
  parameter int RAW_W  = 8,
  localparam int CNT_W  = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2,
  localparam int FLAG_W = dsh_pkg::FLAG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_dst,
  input logic [RAW_W-1:0]  in_cnt,
  input logic              in_dir,
  input logic              in_wide,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_res,
  input logic              out_we,
  input logic [FLAG_W-1:0] out_flags
);
  import dsh_pkg::*;

  logic             fire;
  logic [CNT_W-1:0] cnt_m;
  logic             rc_probe;
  logic             unused_chk;

  assign fire       = in_valid && in_ready;
  assign cnt_m      = in_cnt[CNT_W-1:0];
  assign rc_probe   = in_dst[cnt_m - 1'b1];
  assign unused_chk = ^in_cnt[RAW_W-1:CNT_W];

  AST_ACCEPT_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_we) && $stable(out_flags)); // R10

  AST_ZERO_COUNT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cnt_m == '0 |=> !out_we && out_flags == $past(in_flags)); // R2

  AST_COUNT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cnt_m != '0 |=> out_we); // R2

  AST_UPPER_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_flags[FLAG_W-1:OF_BIT] == $past(in_flags[FLAG_W-1:OF_BIT])); // R9

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_wide |=> out_res[DATA_W-1:HALF_W] == '0); // R12

  AST_RIGHT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_dir && in_wide && cnt_m != '0 |=> out_flags[CF_BIT] == $past(rc_probe)); // R5

  AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_wide && cnt_m != '0 |=> out_flags[SF_BIT] == out_res[DATA_W-1]); // R6
endmodule

bind dshift_unit dshift_chk #(.DATA_W(DATA_W), .RAW_W(RAW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dst(in_dst), .in_cnt(in_cnt), .in_dir(in_dir), .in_wide(in_wide),
  .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
  .out_res(out_res), .out_we(out_we), .out_flags(out_flags)
);

// File: tb/tb_dshift_unit.sv
`timescale 1ns/1ps
module tb_dshift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_dst = '0, in_src = '0;
  logic [7:0]  in_cnt = '0;
  logic        in_dir = 1'b0, in_wide = 1'b1;
  logic [7:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic        out_we;
  logic [7:0]  out_flags;
  logic [1:0]  lat_cycles;

  int    n_checks = 0, n_fail = 0, cycles = 0;
  bit    bp_en = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R10";

  logic        m_valid = 1'b0;
  logic [31:0] m_res;
  logic        m_we;
  logic [7:0]  m_flags;
  string       m_req = "R10";

  dshift_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src(in_src), .in_cnt(in_cnt), .in_dir(in_dir),
    .in_wide(in_wide), .in_flags(in_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_we(out_we),
    .out_flags(out_flags), .lat_cycles(lat_cycles)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ref_op(input logic [31:0] d, input logic [31:0] s, input logic [7:0] raw,
                        input logic dir, input logic wide, input logic [7:0] fi,
                        output logic [31:0] r, output logic we, output logic [7:0] fo);
    int c, w, ones;
    logic [63:0] f;
    logic cy;
    w = wide ? 32 : 16;
    c = int'(raw) % 32;
    fo = fi;
    if (c == 0) begin
      r  = wide ? d : {16'h0, d[15:0]};
      we = 1'b0;
      return;
    end
    if (!dir) begin
      f = wide ? {d, s} : {d[15:0], s[15:0], 32'h0};
      for (int i = 0; i < c; i++) f = f << 1;
      r  = wide ? f[63:32] : {16'h0, f[63:48]};
      cy = (c <= w) ? d[w-c] : 1'b0;
    end else begin
      f = wide ? {s, d} : {32'h0, s[15:0], d[15:0]};
      for (int i = 0; i < c; i++) f = f >> 1;
      r  = wide ? f[31:0] : {16'h0, f[15:0]};
      cy = (c <= w) ? d[c-1] : 1'b0;
    end
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    fo[0] = cy;
    fo[1] = (ones % 2 == 0);
    fo[2] = wide ? (r == 32'h0) : (r[15:0] == 16'h0);
    fo[3] = wide ? r[31] : r[15];
    we = 1'b1;
  endtask

  // behavioural model of the output stage, advanced on each edge
  always @(posedge clk) begin
    if (!rst_n) m_valid = 1'b0;
    else if (in_valid && (!m_valid || out_ready)) begin
      ref_op(in_dst, in_src, in_cnt, in_dir, in_wide, in_flags, m_res, m_we, m_flags);
      m_req   = cur_req;
      m_valid = 1'b1;
    end else if (out_ready) m_valid = 1'b0;
  end

  // comparison every cycle, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(out_valid == m_valid, "R10", "out_valid", 32'(out_valid), 32'(m_valid));
      check(in_ready == (!m_valid || out_ready), "R10", "in_ready", 32'(in_ready),
            32'(!m_valid || out_ready));
      if (m_valid && out_valid) begin
        check(out_res == m_res, m_req, "out_res", out_res, m_res);
        check(out_we == m_we, m_req, "out_we", 32'(out_we), 32'(m_we));
        check(out_flags == m_flags, m_req, "out_flags", 32'(out_flags), 32'(m_flags));
      end
    end
  end

  always @(negedge clk) out_ready = bp_en ? 1'($urandom % 2) : 1'b1;

  task automatic op(input string req, input logic [31:0] d, input logic [31:0] s,
                    input logic [7:0] c, input logic dir, input logic wide, input logic [7:0] fl);
    bit acc;
    @(negedge clk);
    cur_req = req; in_dst = d; in_src = s; in_cnt = c;
    in_dir = dir; in_wide = wide; in_flags = fl; in_valid = 1'b1;
    forever begin
      #1 acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected <100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R10", "reset out_valid", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R10", "reset in_ready", 32'(in_ready), 32'h1);
    check(lat_cycles == 2'd3, "R11", "lat_cycles", 32'(lat_cycles), 32'd3);

    op("R3",  32'h12345678, 32'h9ABCDEF0, 8'd4,   1'b0, 1'b1, 8'h00);
    op("R3",  32'h80000001, 32'hFFFFFFFF, 8'd31,  1'b0, 1'b1, 8'h10);
    op("R4",  32'h12345678, 32'h9ABCDEF0, 8'd8,   1'b1, 1'b1, 8'h00);
    op("R4",  32'h00000001, 32'h00000000, 8'd31,  1'b1, 1'b1, 8'h0F);
    op("R5",  32'h80000000, 32'h00000000, 8'd1,   1'b0, 1'b1, 8'h00);
    op("R5",  32'h40000000, 32'h00000000, 8'd31,  1'b1, 1'b1, 8'h00);
    op("R5",  32'h00008000, 32'h0000FFFF, 8'd16,  1'b0, 1'b0, 8'h00);
    op("R6",  32'h00000000, 32'h00000000, 8'd5,   1'b0, 1'b1, 8'h00);
    op("R6",  32'h00000003, 32'h00000000, 8'd1,   1'b1, 1'b1, 8'h00);
    op("R6",  32'h00004000, 32'h00000001, 8'd1,   1'b0, 1'b0, 8'h00);
    op("R7",  32'h0000ABCD, 32'h00001234, 8'd20,  1'b0, 1'b0, 8'h00);
    op("R7",  32'h0000ABCD, 32'h00001234, 8'd16,  1'b0, 1'b0, 8'h00);
    op("R7",  32'h0000ABCD, 32'h0000F00F, 8'd17,  1'b0, 1'b0, 8'h00);
    op("R8",  32'h0000ABCD, 32'h00001234, 8'd20,  1'b1, 1'b0, 8'h00);
    op("R8",  32'h0000ABCD, 32'h00001234, 8'd16,  1'b1, 1'b0, 8'h00);
    op("R1",  32'h12345678, 32'h9ABCDEF0, 8'hE3,  1'b0, 1'b1, 8'h00);
    op("R1",  32'h12345678, 32'h9ABCDEF0, 8'h20,  1'b1, 1'b1, 8'h5A);
    op("R2",  32'hDEADBEEF, 32'h01234567, 8'h00,  1'b0, 1'b1, 8'hFF);
    op("R2",  32'hDEADBEEF, 32'h01234567, 8'h40,  1'b1, 1'b0, 8'hA5);
    op("R9",  32'h0F0F0F0F, 32'hF0F0F0F0, 8'd7,   1'b0, 1'b1, 8'hF0);
    op("R9",  32'h0F0F0F0F, 32'hF0F0F0F0, 8'd9,   1'b1, 1'b0, 8'hB0);
    op("R12", 32'hFFFF1234, 32'hEEEE5678, 8'd3,   1'b0, 1'b0, 8'h00);
    op("R12", 32'hFFFF1234, 32'hEEEE5678, 8'd3,   1'b1, 1'b0, 8'h00);

    bp_en = 1'b1;
    for (int i = 0; i < 300; i++)
      op("R10", $urandom, $urandom, 8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    bp_en = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(lat_cycles == 2'd3, "R11", "lat_cycles end", 32'(lat_cycles), 32'd3);
    finish_run();
  end
endmodule